// File: doc/BRIEF.md
# Dual Masked Calendar Alarm with Shared Interrupt/Clock Pin

This block compares the running calendar against a set of alarms (two by default). Each alarm holds match values for six calendar fields: seconds, minutes, hours, date, month and day of week. Each field has its own enable bit. Only the enabled fields take part in the comparison. An alarm with only some fields enabled therefore repeats on its own, for example once a minute or every Tuesday. The comparison is made on the cycle in which the one-second tick enable is high, so one matching second produces one event and not a held level.

A match sets a sticky status flag, which the host polls and clears with a per-alarm strobe. An alarm either runs in repeat mode, where it stays armed, or in one-shot mode, where its field enables clear as it fires. A single output pin serves two purposes, chosen by two select bits. In interrupt mode the pin is an active-low interrupt: it goes low while any alarm flag whose interrupt enable is set is high. In the other three settings the pin carries a square wave at 1 Hz, 4096 Hz or 32768 Hz. The wave is built by toggling a level register on the toggle strobe that belongs to the selected rate. Host reads of the time registers take place outside this block and cannot affect an alarm.

The block has two kinds of state machine. Each alarm unit has the states AL_IDLE and AL_ARMED, with these transitions:
- LOAD: an enable load moves the unit to AL_ARMED when the loaded mask is non-zero, and to AL_IDLE when it is zero.
- FIRE_ONESHOT: AL_ARMED goes to AL_IDLE and the mask clears.
- FIRE_REPEAT: AL_ARMED stays in AL_ARMED.

The pin multiplexer has the states OUT_IRQ, OUT_HZ1, OUT_HZ4K and OUT_HZ32K. One transition, MODE_SWITCH, moves it between them one cycle after the select bits change, and it clears the clock level.

Top module: `alarm_irq_top`

## Requirements
- R1: After reset every alarm flag reads 0, every alarm is disarmed (its field mask reads 0) and the pin multiplexer is in OUT_IRQ, so `pin_n` reads 1.
- R2: When `tick_sec` is high and every enabled field of an armed alarm equals the live time field, that alarm's bit in `alm_flag` reads 1 from the next cycle. Field k sits at bits [k*FW +: FW] of the time and value vectors and is enabled by mask bit k. The field order is k=0 second, 1 minute, 2 hour, 3 date, 4 month, 5 day of week.
- R3: Fields whose mask bit is 0 are ignored, so a partial mask fires on every tick on which the enabled fields match, even when the other fields differ.
- R4: An alarm whose mask is all zeros never sets its flag.
- R5: A flag never sets on a cycle without `tick_sec`, even when the time matches.
- R6: An alarm is loaded through `en_load[a]`, which takes `en_data[a*NF +: NF]` as the mask and `rpt_data[a]` as the repeat bit. In one-shot mode (`rpt_data` = 0) the mask clears as the alarm fires, and later matching ticks do not fire it. In repeat mode the alarm fires on every matching tick. A load on the same cycle as a fire takes precedence for the mask.
- R7: A flag stays set until `flag_clr[a]` is pulsed. If a fire and a clear fall on the same cycle, the flag stays set.
- R8: With `fsel` = 0 (OUT_IRQ), `pin_n` is low exactly when some alarm a has both `alm_flag[a]` and `irq_en[a]` high.
- R9: `fsel` = 1, 2 or 3 selects OUT_HZ1, OUT_HZ4K or OUT_HZ32K one cycle later. A mode change drives the pin level to 0. In a clock mode the pin toggles on the cycle after each pulse of the matching strobe (`tog_1hz`, `tog_4k` or `tog_32k`), and the other strobes have no effect on it.
- R10: Alarms are independent: loading or clearing one alarm leaves the other alarm's flag and firing unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_sec | input | 1 | One-cycle enable once per second; the alarms compare only on this cycle |
| time_now | input | NF*FW | Live calendar fields, field k at [k*FW +: FW] |
| alm_val | input | NUM_ALM*NF*FW | Match values; alarm a at [a*NF*FW +: NF*FW] |
| en_load | input | NUM_ALM | Per-alarm strobe that loads the mask and the repeat bit |
| en_data | input | NUM_ALM*NF | Field masks to load; alarm a at [a*NF +: NF] |
| rpt_data | input | NUM_ALM | Repeat bits to load |
| flag_clr | input | NUM_ALM | Per-alarm strobe that clears the flag |
| irq_en | input | NUM_ALM | Per-alarm interrupt enable |
| fsel | input | 2 | Pin function: 0 interrupt, 1 = 1 Hz, 2 = 4096 Hz, 3 = 32768 Hz |
| tog_1hz | input | 1 | Toggle strobe for the 1 Hz wave |
| tog_4k | input | 1 | Toggle strobe for the 4096 Hz wave |
| tog_32k | input | 1 | Toggle strobe for the 32768 Hz wave |
| alm_flag | output | NUM_ALM | Sticky alarm status flags |
| pin_n | output | 1 | Shared pin: active-low interrupt or clock wave |

## Verification
The assertions check these rules on every cycle:
- A flag rises only after a tick.
- A set flag holds until it is cleared.
- A one-shot fire leaves the mask at zero.
- An empty mask never fires.
- A clock-mode pin holds still when its strobe is absent.
- The interrupt pin stays high when no enabled flag is set.

Other behaviour shows only in the bench's scenarios, which compare the design against a behavioural model every clock:
- partial masks firing on several different times;
- precedence when a load and a fire, or a clear and a fire, fall on the same cycle;
- the toggle sequence across mode switches;
- the independence of the two alarms.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
    localparam int FIELDS = 6;

    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DATE = 3;
    localparam int F_MON  = 4;
    localparam int F_DOW  = 5;

    typedef enum logic {
        AL_IDLE  = 1'b0,
        AL_ARMED = 1'b1
    } al_state_e;

    typedef enum logic [1:0] {
        OUT_IRQ   = 2'd0,
        OUT_HZ1   = 2'd1,
        OUT_HZ4K  = 2'd2,
        OUT_HZ32K = 2'd3
    } pin_state_e;
endpackage

// File: rtl/alarm_match.sv
module alarm_match #(
    parameter int NF = alarm_pkg::FIELDS,
    parameter int FW = 8
) (
    input  logic [NF*FW-1:0] now_i,
    input  logic [NF*FW-1:0] val_i,
    input  logic [NF-1:0]    mask_i,
    output logic             hit_o
);
    logic [NF-1:0] field_ok;

    // A masked-out field always agrees; an enabled one must be equal.
    for (genvar k = 0; k < NF; k++) begin : g_field
        assign field_ok[k] = !mask_i[k] || (now_i[k*FW +: FW] == val_i[k*FW +: FW]);
    end

    assign hit_o = &field_ok;
endmodule

// File: rtl/alarm_unit.sv
module alarm_unit
    import alarm_pkg::*;
#(
    parameter int NF = alarm_pkg::FIELDS,
    parameter int FW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_sec,
    input  logic [NF*FW-1:0] now_i,
    input  logic [NF*FW-1:0] val_i,
    input  logic             load_i,
    input  logic [NF-1:0]    load_mask_i,
    input  logic             load_rpt_i,
    input  logic             clr_i,
    output logic             flag_o
);
    al_state_e     state_q, state_d;
    logic [NF-1:0] mask_q, mask_d;
    logic          rpt_q, rpt_d;
    logic          flag_q, flag_d;
    logic          hit;
    logic          fire;

    alarm_match #(.NF(NF), .FW(FW)) u_match (
        .now_i  (now_i),
        .val_i  (val_i),
        .mask_i (mask_q),
        .hit_o  (hit)
    );

    assign fire = tick_sec && (state_q == AL_ARMED) && hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= AL_IDLE;
            mask_q  <= '0;
            rpt_q   <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            mask_q  <= mask_d;
            rpt_q   <= rpt_d;
            flag_q  <= flag_d;
        end
    end

    // Transitions: LOAD, FIRE_ONESHOT, FIRE_REPEAT
    always_comb begin
        state_d = state_q;
        mask_d  = mask_q;
        rpt_d   = rpt_q;
        if (load_i) begin
            mask_d  = load_mask_i;
            rpt_d   = load_rpt_i;
            state_d = (load_mask_i != '0) ? AL_ARMED : AL_IDLE;
        end else begin
            unique case (state_q)
                AL_IDLE: begin
                    state_d = AL_IDLE;
                end
                AL_ARMED: begin
                    if (fire && !rpt_q) begin
                        state_d = AL_IDLE;
                        mask_d  = '0;
                    end
                end
                default: state_d = AL_IDLE;
            endcase
        end
        flag_d = (flag_q && !clr_i) || fire;
    end

    assign flag_o = flag_q;

    AST_RISE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(tick_sec)); // R5
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q); // R7
    AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !rpt_q && !load_i) |=> (mask_q == '0)); // R6
    AST_EMPTY_NEVER_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0 && !flag_q) |=> !flag_q); // R4
endmodule

// File: rtl/pin_mux.sv
module pin_mux
    import alarm_pkg::*;
#(
    parameter int NUM_ALM = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         fsel,
    input  logic               tog_1hz,
    input  logic               tog_4k,
    input  logic               tog_32k,
    input  logic [NUM_ALM-1:0] flags_i,
    input  logic [NUM_ALM-1:0] irq_en_i,
    output logic               pin_n
);
    pin_state_e state_q, state_d;
    logic       lvl_q, lvl_d;
    logic       sel_tog;
    logic       irq_any;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OUT_IRQ;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            lvl_q   <= lvl_d;
        end
    end

    // Next-state and level logic (MODE_SWITCH clears the level)
    always_comb begin
        unique case (fsel)
            2'd0:    state_d = OUT_IRQ;
            2'd1:    state_d = OUT_HZ1;
            2'd2:    state_d = OUT_HZ4K;
            default: state_d = OUT_HZ32K;
        endcase
        unique case (state_q)
            OUT_IRQ:   sel_tog = 1'b0;
            OUT_HZ1:   sel_tog = tog_1hz;
            OUT_HZ4K:  sel_tog = tog_4k;
            default:   sel_tog = tog_32k;
        endcase
        if (state_d != state_q) lvl_d = 1'b0;
        else if (sel_tog)       lvl_d = !lvl_q;
        else                    lvl_d = lvl_q;
    end

    // Output process
    always_comb begin
        irq_any = |(flags_i & irq_en_i);
        unique case (state_q)
            OUT_IRQ: pin_n = !irq_any;
            default: pin_n = lvl_q;
        endcase
    end

    AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != OUT_IRQ && state_d == state_q && !sel_tog) |=> $stable(pin_n)); // R9
    AST_IRQ_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == OUT_IRQ && (flags_i & irq_en_i) == '0) |-> pin_n); // R8
endmodule

// File: rtl/alarm_irq_top.sv
module alarm_irq_top #(
    parameter int NUM_ALM = 2,
    parameter int NF      = alarm_pkg::FIELDS,
    parameter int FW      = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_sec,
    input  logic [NF*FW-1:0]         time_now,
    input  logic [NUM_ALM*NF*FW-1:0] alm_val,
    input  logic [NUM_ALM-1:0]       en_load,
    input  logic [NUM_ALM*NF-1:0]    en_data,
    input  logic [NUM_ALM-1:0]       rpt_data,
    input  logic [NUM_ALM-1:0]       flag_clr,
    input  logic [NUM_ALM-1:0]       irq_en,
    input  logic [1:0]               fsel,
    input  logic                     tog_1hz,
    input  logic                     tog_4k,
    input  logic                     tog_32k,
    output logic [NUM_ALM-1:0]       alm_flag,
    output logic                     pin_n
);
    localparam int TW = NF * FW;

    for (genvar a = 0; a < NUM_ALM; a++) begin : g_alarm
        alarm_unit #(.NF(NF), .FW(FW)) u_unit (
            .clk         (clk),
            .rst_n       (rst_n),
            .tick_sec    (tick_sec),
            .now_i       (time_now),
            .val_i       (alm_val[a*TW +: TW]),
            .load_i      (en_load[a]),
            .load_mask_i (en_data[a*NF +: NF]),
            .load_rpt_i  (rpt_data[a]),
            .clr_i       (flag_clr[a]),
            .flag_o      (alm_flag[a])
        );
    end

    pin_mux #(.NUM_ALM(NUM_ALM)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .fsel     (fsel),
        .tog_1hz  (tog_1hz),
        .tog_4k   (tog_4k),
        .tog_32k  (tog_32k),
        .flags_i  (alm_flag),
        .irq_en_i (irq_en),
        .pin_n    (pin_n)
    );
endmodule

// File: tb/alarm_irq_top_tb.sv
`timescale 1ns/1ps
module alarm_irq_top_tb_top;
    localparam int NA = 2;
    localparam int NF = 6;
    localparam int FW = 8;
    localparam int TW = NF * FW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_sec = 1'b0;
    logic [TW-1:0] time_now = '0;
    logic [NA*TW-1:0] alm_val = '0;
    logic [NA-1:0] en_load = '0;
    logic [NA*NF-1:0] en_data = '0;
    logic [NA-1:0] rpt_data = '0;
    logic [NA-1:0] flag_clr = '0;
    logic [NA-1:0] irq_en = '0;
    logic [1:0] fsel = 2'd0;
    logic tog_1hz = 1'b0, tog_4k = 1'b0, tog_32k = 1'b0;
    logic [NA-1:0] alm_flag;
    logic pin_n;

    int checks = 0;
    int bad = 0;
    string cur_tag = "R1";

    // Reference model state
    logic [NF-1:0] m_mask [NA];
    logic          m_rpt  [NA];
    logic          m_flag [NA];
    int            m_mode = 0;
    logic          m_lvl  = 1'b0;

    always #10 clk = !clk;

    alarm_irq_top #(.NUM_ALM(NA), .NF(NF), .FW(FW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_sec(tick_sec), .time_now(time_now),
        .alm_val(alm_val), .en_load(en_load), .en_data(en_data), .rpt_data(rpt_data),
        .flag_clr(flag_clr), .irq_en(irq_en), .fsel(fsel), .tog_1hz(tog_1hz),
        .tog_4k(tog_4k), .tog_32k(tog_32k), .alm_flag(alm_flag), .pin_n(pin_n)
    );

    function automatic logic [TW-1:0] mk(int s, int mi, int h, int d, int mo, int w);
        logic [TW-1:0] v;
        v = '0;
        v[0*FW +: FW] = FW'(s);
        v[1*FW +: FW] = FW'(mi);
        v[2*FW +: FW] = FW'(h);
        v[3*FW +: FW] = FW'(d);
        v[4*FW +: FW] = FW'(mo);
        v[5*FW +: FW] = FW'(w);
        return v;
    endfunction

    function automatic bit model_hit(int a);
        for (int k = 0; k < NF; k++)
            if (m_mask[a][k] && time_now[k*FW +: FW] != alm_val[a*TW + k*FW +: FW]) return 1'b0;
        return 1'b1;
    endfunction

    initial begin
        for (int a = 0; a < NA; a++) begin
            m_mask[a] = '0; m_rpt[a] = 1'b0; m_flag[a] = 1'b0;
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < NA; a++) begin
                m_mask[a] = '0; m_rpt[a] = 1'b0; m_flag[a] = 1'b0;
            end
            m_mode = 0; m_lvl = 1'b0;
        end else begin
            bit tg;
            for (int a = 0; a < NA; a++) begin
                bit fire;
                fire = tick_sec && (m_mask[a] != '0) && model_hit(a);
                m_flag[a] = (m_flag[a] && !flag_clr[a]) || fire;
                if (en_load[a]) begin
                    m_mask[a] = en_data[a*NF +: NF];
                    m_rpt[a]  = rpt_data[a];
                end else if (fire && !m_rpt[a]) begin
                    m_mask[a] = '0;
                end
            end
            tg = (m_mode == 1 && tog_1hz) || (m_mode == 2 && tog_4k) || (m_mode == 3 && tog_32k);
            if (int'(fsel) != m_mode) m_lvl = 1'b0;
            else if (tg) m_lvl = !m_lvl;
            m_mode = int'(fsel);
        end
    end

    function automatic logic model_pin();
        logic any;
        any = 1'b0;
        for (int a = 0; a < NA; a++) any |= m_flag[a] && irq_en[a];
        return (m_mode == 0) ? !any : m_lvl;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            for (int a = 0; a < NA; a++)
                chk({cur_tag, " flag"}, 32'(alm_flag[a]), 32'(m_flag[a]));
            chk({cur_tag, " pin"}, 32'(pin_n), 32'(model_pin()));
        end
    end

    task automatic go(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic load(int a, logic [NF-1:0] m, logic r);
        en_load[a] = 1'b1; en_data[a*NF +: NF] = m; rpt_data[a] = r;
        go(1);
        en_load[a] = 1'b0;
    endtask

    task automatic tick();
        tick_sec = 1'b1; go(1); tick_sec = 1'b0;
    endtask

    task automatic clr(int a);
        flag_clr[a] = 1'b1; go(1); flag_clr[a] = 1'b0;
    endtask

    bit done = 1'b0;
    initial begin
        #(20 * 200000);
        if (!done) begin
            bad++;
            $display("FAIL watchdog act=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] t0;
        t0 = mk(8'h15, 8'h42, 8'h07, 8'h21, 8'h03, 2);
        go(3);
        // R1 reset state
        chk("R1 flags", 32'(alm_flag), 0);
        chk("R1 pin", 32'(pin_n), 1);
        rst_n = 1'b1;
        go(1);
        chk("R1 pin after release", 32'(pin_n), 1);

        // R2 full match, one-shot
        cur_tag = "R2";
        alm_val[0*TW +: TW] = t0;
        load(0, 6'h3F, 1'b0);
        time_now = t0;
        // R5 matching time without tick
        cur_tag = "R5";
        go(3);
        chk("R5 no tick no flag", 32'(alm_flag[0]), 0);
        cur_tag = "R2";
        tick(); #1;
        chk("R2 full match fires", 32'(alm_flag[0]), 1);
        irq_en = 2'b01; #1;
        chk("R8 pin low with enabled flag", 32'(pin_n), 0);
        irq_en = 2'b00; #1;
        chk("R8 pin high with irq disabled", 32'(pin_n), 1);
        cur_tag = "R7";
        go(4);
        chk("R7 flag sticky", 32'(alm_flag[0]), 1);
        clr(0); #1;
        chk("R7 flag cleared", 32'(alm_flag[0]), 0);
        cur_tag = "R6";
        tick(); #1;
        chk("R6 one-shot disarmed", 32'(alm_flag[0]), 0);

        // R3 partial mask with repeat on alarm 1 (seconds only)
        cur_tag = "R3";
        alm_val[1*TW +: TW] = mk(8'h30, 8'h99, 8'h99, 8'h99, 8'h99, 7);
        load(1, 6'b000001, 1'b1);
        time_now = mk(8'h30, 8'h10, 8'h05, 8'h02, 8'h11, 4);
        tick(); #1;
        chk("R3 seconds-only match", 32'(alm_flag[1]), 1);
        clr(1);
        time_now = mk(8'h31, 8'h10, 8'h05, 8'h02, 8'h11, 4);
        tick(); #1;
        chk("R3 seconds mismatch", 32'(alm_flag[1]), 0);
        cur_tag = "R6";
        time_now = mk(8'h30, 8'h11, 8'h05, 8'h02, 8'h11, 4);
        tick(); #1;
        chk("R6 repeat fires again", 32'(alm_flag[1]), 1);

        // R10 clearing alarm 0 leaves alarm 1
        cur_tag = "R10";
        load(0, 6'b000001, 1'b1);
        alm_val[0*TW +: TW] = mk(8'h30, 0, 0, 0, 0, 0);
        clr(0); #1;
        chk("R10 other flag kept", 32'(alm_flag[1]), 1);
        clr(1);

        // R7 fire and clear on the same cycle
        cur_tag = "R7";
        flag_clr[1] = 1'b1; tick_sec = 1'b1; go(1);
        flag_clr[1] = 1'b0; tick_sec = 1'b0; #1;
        chk("R7 set beats clear", 32'(alm_flag[1]), 1);
        clr(0); clr(1);

        // R4 empty mask never fires
        cur_tag = "R4";
        load(0, 6'b000000, 1'b1);
        tick(); #1;
        chk("R4 empty mask", 32'(alm_flag[0]), 0);

        // R6 load on same cycle as fire: load wins for the mask
        cur_tag = "R6";
        load(0, 6'b000001, 1'b0);
        en_load[0] = 1'b1; en_data[0 +: NF] = 6'b000001; rpt_data[0] = 1'b0;
        tick_sec = 1'b1; go(1);
        en_load[0] = 1'b0; tick_sec = 1'b0; #1;
        chk("R6 fire during load", 32'(alm_flag[0]), 1);
        clr(0);
        tick(); #1;
        chk("R6 reloaded mask fires", 32'(alm_flag[0]), 1);
        clr(0); clr(1);

        // R9 clock modes
        cur_tag = "R9";
        fsel = 2'd1; go(1); #1;
        chk("R9 1Hz level starts low", 32'(pin_n), 0);
        tog_1hz = 1'b1; go(1); tog_1hz = 1'b0; #1;
        chk("R9 1Hz toggle", 32'(pin_n), 1);
        tog_4k = 1'b1; tog_32k = 1'b1; go(1); tog_4k = 1'b0; tog_32k = 1'b0; #1;
        chk("R9 other strobes ignored", 32'(pin_n), 1);
        fsel = 2'd2; go(1); #1;
        chk("R9 mode switch clears", 32'(pin_n), 0);
        tog_4k = 1'b1; go(3); tog_4k = 1'b0; #1;
        chk("R9 4k three toggles", 32'(pin_n), 1);
        fsel = 2'd3; go(1);
        tog_32k = 1'b1; go(2); tog_32k = 1'b0; #1;
        chk("R9 32k two toggles", 32'(pin_n), 0);
        fsel = 2'd0; irq_en = 2'b11; go(2); #1;
        cur_tag = "R8";
        chk("R8 back to irq idle", 32'(pin_n), 1);
        go(3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule